// File: doc/BRIEF.md
# Power-Up Configuration Sequencer

This controller takes an external peripheral, configured over I2C, out of power-down and loads its register settings. It drives the peripheral's active-low power-down pin. It holds that pin low for a minimum time, releases it, and then waits for the peripheral to settle. Only after that does it start any bus traffic. It does not drive the bus itself. Each transaction goes to a separate bit-level I2C master through a request/done handshake, and the master returns an ACK flag with the done pulse.

After the settle wait, the sequencer issues two reads of register 0. The first is a throwaway transaction: its data and its ACK status are discarded. The second is a probe. If the probe is NACKed, the whole power-down toggle is repeated, up to a parameter-limited number of retries. If the probe is ACKed, the sequencer writes a configuration table, held in a parameter array, in index order. It can then optionally write a software-reset bit set and then cleared, so that the peripheral's PLLs recalibrate. The outcome is reported by two flags, done and error.

The low time and the settle time are derived from a clock-frequency parameter and rounded up to whole clock cycles.

Top module: `pwrup_cfg_seq`

## Requirements
- R1: Each power-down low pulse on `pdN` lasts exactly ceil(LOW_NS × CLK_HZ / 1e9) clock cycles, with a minimum of 1.
- R2: After `pdN` rises, `cmdReq` stays low for exactly ceil(SETTLE_US × CLK_HZ / 1e6) cycles. `cmdReq` is never high while `pdN` is low.
- R3: The first command after each power-down release is a read (`cmdRead`=1) of address 0. Its ACK status has no effect on the sequence.
- R4: The second command is a read of address 0. When it is ACKed, the table entries are written in index order. Each entry supplies the address from its upper ADDR_W bits and the data from its lower DATA_W bits.
- R5: When the probe read is NACKed, the sequence restarts from the power-down pulse. After MAX_RETRY retries the next NACK ends in the error state, with no writes issued.
- R6: When SWRST_EN is 1, the table is followed by a write to SWRST_ADDR with only bit SWRST_BIT set, and then a write of 0 to the same address.
- R7: `done` rises in the cycle after the final write's done pulse carries ACK. `done` and `error` are never high together.
- R8: A NACK on any write sets `error`, drops `busy` and stops all further commands.
- R9: A `start` pulse while `busy` is high has no effect on the running sequence.
- R10: After reset, `pdN`=1 and `cmdReq`, `busy`, `done` and `error` are all 0. A `start` in the idle, done or error state clears both flags and drives `pdN` low in the next cycle.
- R11: While `cmdReq` is high and no `cmdDone` has arrived, `cmdReq`, `cmdRead`, `cmdAddr` and `cmdWdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches the sequence when not busy |
| pdN | output | 1 | Active-low power-down pin of the peripheral |
| cmdReq | output | 1 | Command request to the I2C master |
| cmdRead | output | 1 | 1 = read, 0 = write |
| cmdAddr | output | ADDR_W | Register address |
| cmdWdata | output | DATA_W | Write data |
| cmdDone | input | 1 | One-cycle completion pulse from the master |
| cmdAck | input | 1 | ACK status, valid with cmdDone |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Configuration completed |
| error | output | 1 | Retry limit exceeded or write NACKed |

## Verification
A start pulse sampled at a rising edge makes `busy` high and `pdN` low before the following falling edge. The bench checks both at that falling edge.

The low pulse is measured by counting falling-edge samples with `pdN` low, and the settle gap by counting samples with `pdN` high and `cmdReq` low. Each count must equal its cycle figure exactly, not merely reach it.

The modelled master holds each request for a fixed latency and then pulses done for one rising edge. It re-checks that the command fields are stable just before it answers. The flags `done` and `error` are read only after `busy` has fallen, which happens in the cycle after the final done pulse.

// File: rtl/pwrup_cfg_pkg.sv
package pwrup_cfg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PDLOW,
    ST_SETTLE,
    ST_DUMMY,
    ST_PROBE,
    ST_CFG,
    ST_RSTSET,
    ST_RSTCLR,
    ST_DONE,
    ST_FAIL
  } seqState_t;

  typedef enum logic [1:0] {
    SEL_RD0,
    SEL_CFG,
    SEL_RSTSET,
    SEL_RSTCLR
  } cmdSel_t;

  // control -> datapath strobes
  typedef struct packed {
    logic    loadLow;
    logic    loadSettle;
    logic    tmrDec;
    logic    clrRetry;
    logic    incRetry;
    logic    clrIdx;
    logic    incIdx;
    cmdSel_t sel;
  } ctrlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic tmrZero;
    logic retryLeft;
    logic idxLast;
  } dpStatus_t;

  // duration in units of 1/perSec seconds, converted to clock cycles, rounded up
  function automatic longint unsigned ceilCycles(input longint unsigned clkHz,
                                                 input longint unsigned dur,
                                                 input longint unsigned perSec);
    longint unsigned n;
    n = (dur * clkHz + perSec - 1) / perSec;
    if (n == 0) n = 1;
    return n;
  endfunction

endpackage

// File: rtl/pwrup_cfg_dp.sv
module pwrup_cfg_dp
  import pwrup_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned NUM_CFG    = 4,
  parameter int unsigned MAX_RETRY  = 3,
  parameter int unsigned LOW_CYC    = 10,
  parameter int unsigned SETTLE_CYC = 10000,
  parameter int unsigned TMR_W      = 14,
  parameter int unsigned RETRY_W    = 2,
  parameter int unsigned IDX_W      = 2,
  parameter bit          SWRST_EN   = 1'b1,
  parameter logic [ADDR_W-1:0] SWRST_ADDR = '0,
  parameter int unsigned SWRST_BIT  = 0,
  parameter logic [NUM_CFG-1:0][ADDR_W+DATA_W-1:0] CFG_TABLE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  output dpStatus_t         stat,
  output logic              cmdRead,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdWdata
);

  logic [TMR_W-1:0]   tmr;
  logic [RETRY_W-1:0] retryCnt;
  logic [IDX_W-1:0]   idx;
  logic [DATA_W-1:0]  rstSetData;
  logic [ADDR_W+DATA_W-1:0] entry;

  // shared wait timer for low pulse and settle window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       tmr <= '0;
    else if (strb.loadLow)           tmr <= TMR_W'(LOW_CYC - 1);
    else if (strb.loadSettle)        tmr <= TMR_W'(SETTLE_CYC - 1);
    else if (strb.tmrDec && tmr != 0) tmr <= tmr - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              retryCnt <= '0;
    else if (strb.clrRetry) retryCnt <= '0;
    else if (strb.incRetry) retryCnt <= retryCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            idx <= '0;
    else if (strb.clrIdx) idx <= '0;
    else if (strb.incIdx) idx <= idx + 1'b1;
  end

  assign stat.tmrZero   = (tmr == '0);
  assign stat.retryLeft = (retryCnt != RETRY_W'(MAX_RETRY));
  assign stat.idxLast   = (idx == IDX_W'(NUM_CFG - 1));

  generate
    if (SWRST_EN) begin : g_swrst
      assign rstSetData = DATA_W'(1) << SWRST_BIT;
    end else begin : g_noSwrst
      assign rstSetData = '0;
    end
  endgenerate

  assign entry = CFG_TABLE[idx];

  always_comb begin
    cmdRead  = 1'b0;
    cmdAddr  = '0;
    cmdWdata = '0;
    unique case (strb.sel)
      SEL_RD0: cmdRead = 1'b1;
      SEL_CFG: begin
        cmdAddr  = entry[ADDR_W+DATA_W-1:DATA_W];
        cmdWdata = entry[DATA_W-1:0];
      end
      SEL_RSTSET: begin
        cmdAddr  = SWRST_ADDR;
        cmdWdata = rstSetData;
      end
      SEL_RSTCLR: cmdAddr = SWRST_ADDR;
      default: cmdRead = 1'b1;
    endcase
  end

endmodule

// File: rtl/pwrup_cfg_ctrl.sv
module pwrup_cfg_ctrl
  import pwrup_cfg_pkg::*;
#(
  parameter bit SWRST_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        cmdDone,
  input  logic        cmdAck,
  input  dpStatus_t   stat,
  output ctrlStrobe_t strb,
  output logic        cmdReq,
  output logic        pdN,
  output logic        busy,
  output logic        done,
  output logic        error
);

  seqState_t state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt      = state;
    strb     = '0;
    strb.sel = SEL_RD0;
    unique case (state)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (start) begin
          nxt           = ST_PDLOW;
          strb.loadLow  = 1'b1;
          strb.clrRetry = 1'b1;
          strb.clrIdx   = 1'b1;
        end
      end
      ST_PDLOW: begin
        strb.tmrDec = 1'b1;
        if (stat.tmrZero) begin
          nxt             = ST_SETTLE;
          strb.loadSettle = 1'b1;
        end
      end
      ST_SETTLE: begin
        strb.tmrDec = 1'b1;
        if (stat.tmrZero) nxt = ST_DUMMY;
      end
      ST_DUMMY: begin
        if (cmdDone) nxt = ST_PROBE;
      end
      ST_PROBE: begin
        if (cmdDone) begin
          if (cmdAck) begin
            nxt         = ST_CFG;
            strb.clrIdx = 1'b1;
          end else if (stat.retryLeft) begin
            nxt           = ST_PDLOW;
            strb.incRetry = 1'b1;
            strb.loadLow  = 1'b1;
          end else begin
            nxt = ST_FAIL;
          end
        end
      end
      ST_CFG: begin
        strb.sel = SEL_CFG;
        if (cmdDone) begin
          if (!cmdAck)           nxt = ST_FAIL;
          else if (stat.idxLast) nxt = SWRST_EN ? ST_RSTSET : ST_DONE;
          else                   strb.incIdx = 1'b1;
        end
      end
      ST_RSTSET: begin
        strb.sel = SEL_RSTSET;
        if (cmdDone) nxt = cmdAck ? ST_RSTCLR : ST_FAIL;
      end
      ST_RSTCLR: begin
        strb.sel = SEL_RSTCLR;
        if (cmdDone) nxt = cmdAck ? ST_DONE : ST_FAIL;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign cmdReq = (state == ST_DUMMY) || (state == ST_PROBE) || (state == ST_CFG) ||
                  (state == ST_RSTSET) || (state == ST_RSTCLR);
  assign pdN    = (state != ST_PDLOW);
  assign done   = (state == ST_DONE);
  assign error  = (state == ST_FAIL);
  assign busy   = !((state == ST_IDLE) || (state == ST_DONE) || (state == ST_FAIL));

endmodule

// File: rtl/pwrup_cfg_seq.sv
module pwrup_cfg_seq
  import pwrup_cfg_pkg::*;
#(
  parameter longint unsigned CLK_HZ    = 50_000_000,
  parameter longint unsigned LOW_NS    = 200,
  parameter longint unsigned SETTLE_US = 200,
  parameter int unsigned     MAX_RETRY = 3,
  parameter int unsigned     NUM_CFG   = 4,
  parameter int unsigned     ADDR_W    = 8,
  parameter int unsigned     DATA_W    = 8,
  parameter logic [NUM_CFG-1:0][ADDR_W+DATA_W-1:0] CFG_TABLE =
    {16'h1303, 16'h1202, 16'h1101, 16'h1000},
  parameter bit              SWRST_EN   = 1'b1,
  parameter logic [ADDR_W-1:0] SWRST_ADDR = 8'h0C,
  parameter int unsigned     SWRST_BIT  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              pdN,
  output logic              cmdReq,
  output logic              cmdRead,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdWdata,
  input  logic              cmdDone,
  input  logic              cmdAck,
  output logic              busy,
  output logic              done,
  output logic              error
);

  localparam int unsigned LOW_CYC    = 32'(ceilCycles(CLK_HZ, LOW_NS, 64'd1_000_000_000));
  localparam int unsigned SETTLE_CYC = 32'(ceilCycles(CLK_HZ, SETTLE_US, 64'd1_000_000));
  localparam int unsigned TMR_MAX    = (LOW_CYC > SETTLE_CYC) ? LOW_CYC : SETTLE_CYC;
  localparam int unsigned TMR_W      = $clog2(TMR_MAX + 1);
  localparam int unsigned RETRY_W    = (MAX_RETRY > 0) ? $clog2(MAX_RETRY + 1) : 1;
  localparam int unsigned IDX_W      = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1;

  ctrlStrobe_t strb;
  dpStatus_t   stat;

  pwrup_cfg_ctrl #(.SWRST_EN(SWRST_EN)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cmdDone(cmdDone), .cmdAck(cmdAck),
    .stat(stat), .strb(strb), .cmdReq(cmdReq), .pdN(pdN), .busy(busy),
    .done(done), .error(error)
  );

  pwrup_cfg_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CFG(NUM_CFG), .MAX_RETRY(MAX_RETRY),
    .LOW_CYC(LOW_CYC), .SETTLE_CYC(SETTLE_CYC), .TMR_W(TMR_W), .RETRY_W(RETRY_W),
    .IDX_W(IDX_W), .SWRST_EN(SWRST_EN), .SWRST_ADDR(SWRST_ADDR),
    .SWRST_BIT(SWRST_BIT), .CFG_TABLE(CFG_TABLE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .stat(stat),
    .cmdRead(cmdRead), .cmdAddr(cmdAddr), .cmdWdata(cmdWdata)
  );

endmodule

// File: rtl/pwrup_cfg_chk.sv
module pwrup_cfg_chk #(
  parameter int unsigned LOW_CYC = 1,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              pdN,
  input logic              cmdReq,
  input logic              cmdRead,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic [DATA_W-1:0] cmdWdata,
  input logic              cmdDone,
  input logic              busy,
  input logic              done,
  input logic              error
);

  int unsigned lowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     lowRun <= 0;
    else if (!pdN) lowRun <= lowRun + 1;
    else           lowRun <= 0;
  end

  // R1: completed low pulse has the exact cycle length
  p_low_len_r1: assert property (@(posedge clk) disable iff (!rstN)
    (pdN && lowRun != 0) |-> (lowRun == LOW_CYC));

  // R2: no bus request while the peripheral is held in power-down
  p_no_req_pd_r2: assert property (@(posedge clk) disable iff (!rstN)
    !pdN |-> !cmdReq);

  // R7: outcome flags exclusive
  p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

  // R8: error state is quiet
  p_fail_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    error |-> (!cmdReq && !busy));

  // R9: start during the settle window does not re-enter power-down
  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && pdN && !cmdReq && start) |=> pdN);

  // R11: request and command fields held until completion
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReq && !cmdDone) |=> (cmdReq && $stable(cmdRead) && $stable(cmdAddr) && $stable(cmdWdata)));

endmodule

bind pwrup_cfg_seq pwrup_cfg_chk #(.LOW_CYC(LOW_CYC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .pdN(pdN), .cmdReq(cmdReq), .cmdRead(cmdRead),
  .cmdAddr(cmdAddr), .cmdWdata(cmdWdata), .cmdDone(cmdDone), .busy(busy),
  .done(done), .error(error)
);

// File: tb/sim_pwrup_cfg_seq.sv
module sim_pwrup_cfg_seq;

  localparam int CLK_PERIOD = 10;
  localparam int LOW_CYC    = 2;     // ceil(200 ns * 10 MHz)
  localparam int SETTLE_CYC = 2000;  // ceil(200 us * 10 MHz)
  localparam int LAT        = 3;
  localparam int LOGMAX     = 32;
  // probeNacks, nackWrite(-1 none), dummyAck, expDone, expPulses
  localparam int SCN [0:5][0:4] = '{
    '{0, -1, 1, 1, 1},
    '{1, -1, 0, 1, 2},
    '{2, -1, 1, 1, 3},
    '{3, -1, 1, 0, 3},
    '{0,  1, 1, 0, 1},
    '{0,  3, 0, 0, 1}
  };

  logic clk = 0, rstN, start;
  logic pdN, cmdReq, cmdRead, cmdDone, cmdAck, busy, done, error;
  logic [7:0] cmdAddr, cmdWdata;

  int nChecks = 0, nFails = 0;
  int logN, pulses, rdCount, wrCount, probeNacksLeft, nackWrite, dummyAck;
  int lowRun = 0, quiet = 0;
  bit armed = 0;
  bit   logRd [LOGMAX];
  logic [7:0] logAddr [LOGMAX];
  logic [7:0] logData [LOGMAX];
  bit   wRd [5] = '{0, 0, 0, 0, 0};
  logic [7:0] wAddr [5] = '{8'h10, 8'h11, 8'h12, 8'h0C, 8'h0C};
  logic [7:0] wData [5] = '{8'hA1, 8'hB2, 8'hC3, 8'h40, 8'h00};

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrup_cfg_seq #(
    .CLK_HZ(10_000_000), .MAX_RETRY(2), .NUM_CFG(3),
    .CFG_TABLE({16'h12C3, 16'h11B2, 16'h10A1}),
    .SWRST_EN(1'b1), .SWRST_ADDR(8'h0C), .SWRST_BIT(6)
  ) u0 (
    .clk(clk), .rstN(rstN), .start(start), .pdN(pdN), .cmdReq(cmdReq),
    .cmdRead(cmdRead), .cmdAddr(cmdAddr), .cmdWdata(cmdWdata),
    .cmdDone(cmdDone), .cmdAck(cmdAck), .busy(busy), .done(done), .error(error)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // I2C master model
  initial begin
    cmdDone = 0; cmdAck = 0;
    forever begin
      @(negedge clk);
      if (cmdReq === 1'b1 && rstN) begin
        bit r, ackV;
        logic [7:0] a, d;
        r = cmdRead; a = cmdAddr; d = cmdWdata;
        if (logN < LOGMAX) begin
          logRd[logN] = r; logAddr[logN] = a; logData[logN] = d;
        end
        logN++;
        if (r) begin
          if (rdCount % 2 == 0) ackV = dummyAck[0];
          else if (probeNacksLeft > 0) begin ackV = 0; probeNacksLeft--; end
          else ackV = 1;
          rdCount++;
        end else begin
          ackV = (wrCount != nackWrite);
          wrCount++;
        end
        repeat (LAT) @(negedge clk);
        check(cmdReq === 1'b1 && cmdRead === r && cmdAddr === a && cmdWdata === d,
              "R11", int'(cmdAddr), int'(a));
        cmdDone = 1; cmdAck = ackV;
        @(negedge clk);
        cmdDone = 0; cmdAck = 0;
      end
    end
  end

  // power-down pulse and settle window monitor
  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      if (!pdN) begin
        lowRun++; armed = 1; quiet = 0;
      end else begin
        if (lowRun > 0) begin
          check(lowRun == LOW_CYC, "R1", lowRun, LOW_CYC);
          pulses++; lowRun = 0;
        end
        if (armed) begin
          if (cmdReq) begin
            check(quiet == SETTLE_CYC, "R2", quiet, SETTLE_CYC);
            armed = 0;
          end else quiet++;
        end
      end
    end
  end

  task automatic pulseStart();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic prep(input int pn, input int nw, input int da);
    probeNacksLeft = pn; nackWrite = nw; dummyAck = da;
    logN = 0; pulses = 0; rdCount = 0; wrCount = 0;
  endtask

  task automatic runScenario(input int s);
    int expDone, expPulses, nW, expN, nw;
    nw = SCN[s][1];
    prep(SCN[s][0], nw, SCN[s][2]);
    expDone = SCN[s][3]; expPulses = SCN[s][4];
    pulseStart();
    check(busy === 1 && done === 0 && error === 0 && pdN === 0, "R10", int'(done) + int'(error), 0);
    while (busy) @(negedge clk);
    if (expDone == 1) nW = 5;
    else if (nw >= 0) nW = nw + 1;
    else nW = 0;
    expN = expPulses * 2 + nW;
    check(done === expDone[0], "R7", int'(done), expDone);
    if (SCN[s][2] == 0 && expDone == 1) check(done === 1, "R3", int'(done), 1);
    check(error === !expDone[0], (nw >= 0) ? "R8" : "R5", int'(error), 1 - expDone);
    check(pulses == expPulses, "R5", pulses, expPulses);
    check(logN == expN, "R4", logN, expN);
    for (int i = 0; i < expN && i < logN; i++) begin
      if (i < expPulses * 2)
        check(logRd[i] == 1 && logAddr[i] == 0, "R3", int'(logAddr[i]), 0);
      else begin
        int k;
        k = i - expPulses * 2;
        check(logRd[i] == wRd[k] && logAddr[i] == wAddr[k] && logData[i] == wData[k],
              (k < 3) ? "R4" : "R6", int'(logData[i]), int'(wData[k]));
      end
    end
    if (expDone == 0) begin
      repeat (20) @(negedge clk);
      check(logN == expN && cmdReq === 0, "R8", logN, expN);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 0; start = 0;
    prep(0, -1, 1);
    repeat (3) @(negedge clk);
    check(pdN === 1 && cmdReq === 0 && busy === 0 && done === 0 && error === 0,
          "R10", int'(busy), 0);
    rstN = 1;
    @(negedge clk);
    check(pdN === 1 && cmdReq === 0 && busy === 0 && done === 0 && error === 0,
          "R10", int'(busy), 0);

    for (int s = 0; s < 6; s++) runScenario(s);

    // R9: extra start while busy
    prep(0, -1, 1);
    pulseStart();
    repeat (500) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    while (busy) @(negedge clk);
    check(pulses == 1, "R9", pulses, 1);
    check(logN == 7 && done === 1, "R9", logN, 7);

    // R10: start from done clears flag
    prep(0, -1, 1);
    pulseStart();
    check(done === 0 && busy === 1, "R10", int'(done), 0);
    while (busy) @(negedge clk);
    check(done === 1, "R7", int'(done), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule